// File: doc/BRIEF.md
# IPv4 Receive Header Parser

This block sits behind an Ethernet receive path that delivers one byte per clock with a valid qualifier and an end-of-frame marker. It walks the Ethernet and IPv4 headers of every frame and keeps only IPv4 datagrams whose destination address equals the configured local address. Other frames are dropped without comment. Frames that break off inside the header, or whose first IPv4 byte is not the plain 20-byte version-4 form, are counted as errors, and the kind of the most recent error is kept.

For an accepted datagram the block strips the 34 header bytes and forwards each payload byte one cycle after it arrives. The first payload byte carries a start pulse. The protocol number, the source address and the payload length (total length minus the 20-byte header) appear with that first byte, together with a header-valid flag. An 8-bit counter records the accepted datagrams.

Payload bytes are forwarded until the frame ends, so any trailing Ethernet padding passes through. Fragments are forwarded as they arrive, and IP options are not interpreted. The header checksum is not checked.

Top module: `ipv4_rx_parser`

## Requirements
- R1: A frame whose bytes 12 and 13 (zero-based) are not 0x08 and 0x00 is discarded up to its in_last: no payload output, and no counter or error code changes.
- R2: Frame bytes 30..33 must equal local_ip, byte 30 against local_ip[31:24] down to byte 33 against local_ip[7:0]. On a mismatch the frame is discarded silently, as in R1.
- R3: hdr_proto takes byte 23. hdr_src_ip takes bytes 26..29, with byte 26 as the most significant. hdr_len is {byte16,byte17} minus 20, modulo 2^16. These three outputs change only in the cycle in which pay_start is high.
- R4: Payload byte 34 of an accepted frame appears on pay_data one cycle after it is taken in. In that cycle pay_valid, pay_start and hdr_valid are all high. pay_start is high for that first byte only.
- R5: pay_last is high with the forwarded byte that arrived with in_last. One cycle after pay_last, hdr_valid is low, unless a new pay_start arrives in that same cycle.
- R6: A cycle with in_valid low does not advance the walk. The following cycle shows pay_valid, pay_last and pay_start low. pay_data is zero whenever pay_valid is low.
- R7: While reset is held and right after it is released, all outputs are zero.
- R8: If in_last arrives at a byte below 34 while the frame has passed every check so far, err_count increments (wrapping at 8 bits) and err_code becomes 1 (truncated).
- R9: If byte 14 is not 0x45 in a frame that passed the type check, err_count increments, err_code becomes 2 (bad version or header length), and the rest of the frame is discarded.
- R10: A well-formed accepted frame leaves err_count and err_code unchanged, so both stay 0 after reset.
- R11: pkt_count increments by one in the cycle of each pay_start and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_ip | input | 32 | Local IPv4 address used to filter destinations |
| in_data | input | 8 | Received frame byte |
| in_valid | input | 1 | in_data holds a byte this cycle |
| in_last | input | 1 | The byte is the final byte of its frame |
| pay_data | output | 8 | Forwarded payload byte |
| pay_valid | output | 1 | pay_data holds a payload byte |
| pay_last | output | 1 | Final payload byte of the datagram |
| pay_start | output | 1 | First payload byte of the datagram |
| hdr_valid | output | 1 | Header outputs describe the datagram being forwarded |
| hdr_proto | output | 8 | IPv4 protocol number |
| hdr_len | output | 16 | Payload length derived from the total length |
| hdr_src_ip | output | 32 | IPv4 source address |
| pkt_count | output | 8 | Accepted datagrams, wrapping |
| err_count | output | 8 | Header errors, wrapping |
| err_code | output | 4 | Most recent error kind: 0 none, 1 truncated, 2 bad version byte |

## Verification
A byte index that is off by one moves every capture and the destination compare. The result is visible at the first payload byte of the next good frame, about 35 cycles after its start: wrong fields, a missing pay_start, or a spurious error count. A walk state that fails to return to idle after in_last shows within one frame, because the next frame's payload never appears or appears at the wrong cycle. The reference model is compared on every clock, so a corrupted counter or a stale hdr_valid is reported in the first cycle it differs.

// File: rtl/ipv4_rx_pkg.sv
`timescale 1ns/1ps
package ipv4_rx_pkg;

   typedef enum logic [1:0] {
      ST_WALK = 2'd0,
      ST_DROP = 2'd1,
      ST_PASS = 2'd2
   } walk_st_e;

   localparam int unsigned ETH_BYTES  = 14;
   localparam int unsigned IP_BYTES   = 20;
   localparam int unsigned HDR_LEN    = ETH_BYTES + IP_BYTES;
   localparam int unsigned IDX_W      = $clog2(HDR_LEN);
   localparam int unsigned ADDR_BYTES = 4;

   // byte offsets that neighbours decode; order is fixed by the wire format
   localparam int unsigned OFS_TYPE_HI = 12;
   localparam int unsigned OFS_TYPE_LO = 13;
   localparam int unsigned OFS_VER     = 14;
   localparam int unsigned OFS_TLEN_HI = 16;
   localparam int unsigned OFS_TLEN_LO = 17;
   localparam int unsigned OFS_PROTO   = 23;
   localparam int unsigned OFS_SRC     = 26;
   localparam int unsigned OFS_DST     = 30;

   localparam logic [15:0] TYPE_IPV4     = 16'h0800;
   localparam logic [7:0]  VER_IHL_PLAIN = 8'h45;

   localparam int unsigned CODE_NONE   = 0;
   localparam int unsigned CODE_TRUNC  = 1;
   localparam int unsigned CODE_BADVER = 2;

endpackage

// File: rtl/ipv4_rx_walker.sv
`timescale 1ns/1ps
module ipv4_rx_walker
   import ipv4_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [31:0]      local_ip,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   input  logic             in_last,
   output logic [IDX_W-1:0] hdr_idx,
   output logic             hdr_stb,
   output logic             pass_stb,
   output logic             pass_first,
   output logic             ver_err,
   output logic             trunc_err
);

   walk_st_e         st_q, st_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             first_q, first_d;
   logic [1:0]       dsel;
   logic [7:0]       dst_exp;
   logic             filt_miss;
   logic             ver_bad;
   logic             hdr_done;

   assign dsel     = 2'(IDX_W'(HDR_LEN - 1) - idx_q);
   assign dst_exp  = local_ip[8*dsel +: 8];
   assign hdr_done = (idx_q == IDX_W'(HDR_LEN - 1));
   assign ver_bad  = (idx_q == IDX_W'(OFS_VER)) && (in_data != VER_IHL_PLAIN);

   always_comb begin
      filt_miss = 1'b0;
      if (idx_q == IDX_W'(OFS_TYPE_HI) && in_data != TYPE_IPV4[15:8]) filt_miss = 1'b1;
      if (idx_q == IDX_W'(OFS_TYPE_LO) && in_data != TYPE_IPV4[7:0])  filt_miss = 1'b1;
      if (idx_q >= IDX_W'(OFS_DST) && in_data != dst_exp)             filt_miss = 1'b1;
   end

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      first_d   = first_q;
      ver_err   = 1'b0;
      trunc_err = 1'b0;
      if (in_valid) begin
         unique case (st_q)
            ST_WALK: begin
               if (filt_miss) begin
                  st_d  = in_last ? ST_WALK : ST_DROP;
                  idx_d = '0;
               end else if (ver_bad) begin
                  ver_err = 1'b1;
                  st_d    = in_last ? ST_WALK : ST_DROP;
                  idx_d   = '0;
               end else if (in_last) begin
                  trunc_err = 1'b1;
                  idx_d     = '0;
               end else if (hdr_done) begin
                  st_d    = ST_PASS;
                  first_d = 1'b1;
                  idx_d   = '0;
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
            ST_DROP: begin
               if (in_last) st_d = ST_WALK;
            end
            ST_PASS: begin
               first_d = 1'b0;
               if (in_last) st_d = ST_WALK;
            end
            default: st_d = ST_WALK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_WALK;
         idx_q   <= '0;
         first_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         idx_q   <= idx_d;
         first_q <= first_d;
      end
   end

   assign hdr_idx    = idx_q;
   assign hdr_stb    = in_valid && (st_q == ST_WALK);
   assign pass_stb   = in_valid && (st_q == ST_PASS);
   assign pass_first = first_q;

endmodule

// File: rtl/ipv4_rx_capture.sv
`timescale 1ns/1ps
module ipv4_rx_capture
   import ipv4_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic [IDX_W-1:0] hdr_idx,
   input  logic             hdr_stb,
   input  logic             pass_stb,
   input  logic             pass_first,
   output logic [7:0]       pay_data,
   output logic             pay_valid,
   output logic             pay_last,
   output logic             pay_start,
   output logic             hdr_valid,
   output logic [7:0]       hdr_proto,
   output logic [15:0]      hdr_len,
   output logic [31:0]      hdr_src_ip
);

   localparam logic [15:0] HDR_SUB = 16'(IP_BYTES);

   logic [15:0] tlen_s;
   logic [7:0]  proto_s;
   logic [31:0] src_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         tlen_s  <= '0;
         proto_s <= '0;
      end else if (hdr_stb) begin
         if (hdr_idx == IDX_W'(OFS_TLEN_HI)) tlen_s[15:8] <= in_data;
         if (hdr_idx == IDX_W'(OFS_TLEN_LO)) tlen_s[7:0]  <= in_data;
         if (hdr_idx == IDX_W'(OFS_PROTO))   proto_s      <= in_data;
      end
   end

   // one shadow byte per source address byte, most significant first
   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_src
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (rst)
            b_q <= '0;
         else if (hdr_stb && hdr_idx == IDX_W'(OFS_SRC + g))
            b_q <= in_data;
      end
      assign src_w[31 - 8*g -: 8] = b_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pay_data   <= '0;
         pay_valid  <= 1'b0;
         pay_last   <= 1'b0;
         pay_start  <= 1'b0;
         hdr_valid  <= 1'b0;
         hdr_proto  <= '0;
         hdr_len    <= '0;
         hdr_src_ip <= '0;
      end else begin
         pay_valid <= pass_stb;
         pay_data  <= pass_stb ? in_data : 8'h00;
         pay_last  <= pass_stb && in_last;
         pay_start <= pass_stb && pass_first;
         if (pass_stb && pass_first) begin
            hdr_valid  <= 1'b1;
            hdr_proto  <= proto_s;
            hdr_len    <= tlen_s - HDR_SUB;
            hdr_src_ip <= src_w;
         end else if (pay_last) begin
            hdr_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ipv4_rx_stats.sv
`timescale 1ns/1ps
module ipv4_rx_stats
   import ipv4_rx_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned ERRC_W       = 8,
   parameter int unsigned CODE_W       = 4,
   parameter bit          ERR_SATURATE = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              ver_err,
   input  logic              trunc_err,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [ERRC_W-1:0] err_count,
   output logic [CODE_W-1:0] err_code
);

   logic [ERRC_W-1:0] err_next;

   if (ERR_SATURATE) begin : g_err_sat
      assign err_next = (&err_count) ? err_count : err_count + 1'b1;
   end else begin : g_err_wrap
      assign err_next = err_count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pkt_count <= '0;
         err_count <= '0;
         err_code  <= CODE_W'(CODE_NONE);
      end else begin
         if (accept) pkt_count <= pkt_count + 1'b1;
         if (ver_err || trunc_err) begin
            err_count <= err_next;
            err_code  <= trunc_err ? CODE_W'(CODE_TRUNC) : CODE_W'(CODE_BADVER);
         end
      end
   end

endmodule

// File: rtl/ipv4_rx_parser.sv
`timescale 1ns/1ps
module ipv4_rx_parser
   import ipv4_rx_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned ERRC_W       = 8,
   parameter int unsigned CODE_W       = 4,
   parameter bit          ERR_SATURATE = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       local_ip,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic [7:0]        pay_data,
   output logic              pay_valid,
   output logic              pay_last,
   output logic              pay_start,
   output logic              hdr_valid,
   output logic [7:0]        hdr_proto,
   output logic [15:0]       hdr_len,
   output logic [31:0]       hdr_src_ip,
   output logic [CNT_W-1:0]  pkt_count,
   output logic [ERRC_W-1:0] err_count,
   output logic [CODE_W-1:0] err_code
);

   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end
   if (ERRC_W < 1) begin : g_chk_errc
      $error("ERRC_W must be at least 1");
   end
   if (CODE_W < 2) begin : g_chk_code
      $error("CODE_W must hold the codes 0..2");
   end

   logic [IDX_W-1:0] hdr_idx;
   logic             hdr_stb;
   logic             pass_stb;
   logic             pass_first;
   logic             ver_err;
   logic             trunc_err;

   ipv4_rx_walker u_walk (
      .clk        (clk),
      .rst        (rst),
      .local_ip   (local_ip),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .hdr_idx    (hdr_idx),
      .hdr_stb    (hdr_stb),
      .pass_stb   (pass_stb),
      .pass_first (pass_first),
      .ver_err    (ver_err),
      .trunc_err  (trunc_err)
   );

   ipv4_rx_capture u_cap (
      .clk        (clk),
      .rst        (rst),
      .in_data    (in_data),
      .in_last    (in_last),
      .hdr_idx    (hdr_idx),
      .hdr_stb    (hdr_stb),
      .pass_stb   (pass_stb),
      .pass_first (pass_first),
      .pay_data   (pay_data),
      .pay_valid  (pay_valid),
      .pay_last   (pay_last),
      .pay_start  (pay_start),
      .hdr_valid  (hdr_valid),
      .hdr_proto  (hdr_proto),
      .hdr_len    (hdr_len),
      .hdr_src_ip (hdr_src_ip)
   );

   ipv4_rx_stats #(
      .CNT_W        (CNT_W),
      .ERRC_W       (ERRC_W),
      .CODE_W       (CODE_W),
      .ERR_SATURATE (ERR_SATURATE)
   ) u_stats (
      .clk       (clk),
      .rst       (rst),
      .accept    (pass_stb && pass_first),
      .ver_err   (ver_err),
      .trunc_err (trunc_err),
      .pkt_count (pkt_count),
      .err_count (err_count),
      .err_code  (err_code)
   );

endmodule

// File: rtl/ipv4_rx_parser_chk.sv
`timescale 1ns/1ps
module ipv4_rx_parser_chk #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned ERRC_W = 8,
   parameter int unsigned CODE_W = 4
)(
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [7:0]        pay_data,
   input logic              pay_valid,
   input logic              pay_last,
   input logic              pay_start,
   input logic              hdr_valid,
   input logic [7:0]        hdr_proto,
   input logic [15:0]       hdr_len,
   input logic [31:0]       hdr_src_ip,
   input logic [CNT_W-1:0]  pkt_count,
   input logic [ERRC_W-1:0] err_count,
   input logic [CODE_W-1:0] err_code
);

   p_fields_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !pay_start |-> ($stable(hdr_proto) && $stable(hdr_len) && $stable(hdr_src_ip)));

   p_start_flags_r4: assert property (@(posedge clk) disable iff (rst)
      pay_start |-> (pay_valid && hdr_valid));

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      pay_start |=> !pay_start);

   p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
      pay_last |-> pay_valid);

   p_hdr_clear_r5: assert property (@(posedge clk) disable iff (rst)
      pay_last |=> (pay_start || !hdr_valid));

   p_idle_out_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !pay_valid);

   p_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
      !pay_valid |-> (pay_data == 8'h00));

   p_err_code_set_r8: assert property (@(posedge clk) disable iff (rst)
      (err_count != $past(err_count)) |-> (err_code != '0));

   p_pkt_step_r11: assert property (@(posedge clk) disable iff (rst)
      pay_start |-> (pkt_count == CNT_W'($past(pkt_count) + 1'b1)));

   p_pkt_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !pay_start |-> $stable(pkt_count));

endmodule

bind ipv4_rx_parser ipv4_rx_parser_chk #(
   .CNT_W  (CNT_W),
   .ERRC_W (ERRC_W),
   .CODE_W (CODE_W)
) u_chk (.*);

// File: tb/ipv4_rx_parser_tb.sv
`timescale 1ns/1ps
module ipv4_rx_parser_tb_top;

   localparam logic [31:0] LOCAL = 32'hc0a80509;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] local_ip = LOCAL;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic [7:0]  pay_data;
   logic        pay_valid, pay_last, pay_start, hdr_valid;
   logic [7:0]  hdr_proto;
   logic [15:0] hdr_len;
   logic [31:0] hdr_src_ip;
   logic [7:0]  pkt_count, err_count;
   logic [3:0]  err_code;

   always #2.5 clk = ~clk;

   ipv4_rx_parser dut_i (
      .clk(clk), .rst(rst), .local_ip(local_ip),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
      .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
      .pay_start(pay_start), .hdr_valid(hdr_valid), .hdr_proto(hdr_proto),
      .hdr_len(hdr_len), .hdr_src_ip(hdr_src_ip), .pkt_count(pkt_count),
      .err_count(err_count), .err_code(err_code)
   );

   int    vectors = 0;
   int    fails   = 0;
   bit    done    = 0;
   string cur_req = "R7";

   // reference model state
   logic [7:0] fq[$];
   int         mode = 0;    // 0 header, 1 dropping, 2 forwarding
   int         npay = 0;
   logic [7:0] e_pd = 0;
   logic       e_pv = 0, e_pl = 0, e_ps = 0, e_hv = 0;
   logic [7:0] e_proto = 0;
   logic [15:0] e_len = 0;
   logic [31:0] e_src = 0;
   int         e_pkts = 0, e_errs = 0, e_code = 0;
   logic [7:0] fr[$];

   task automatic cmp(string fld, string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s (%s) t=%0t: actual %h expected %h", req, cur_req, fld, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      cmp("hdr_valid",  "R4",  32'(hdr_valid),  32'(e_hv));
      cmp("hdr_proto",  "R3",  32'(hdr_proto),  32'(e_proto));
      cmp("hdr_len",    "R3",  32'(hdr_len),    32'(e_len));
      cmp("hdr_src_ip", "R3",  hdr_src_ip,      e_src);
      cmp("pay_valid",  "R6",  32'(pay_valid),  32'(e_pv));
      cmp("pay_data",   "R4",  32'(pay_data),   32'(e_pd));
      cmp("pay_last",   "R5",  32'(pay_last),   32'(e_pl));
      cmp("pay_start",  "R4",  32'(pay_start),  32'(e_ps));
      cmp("pkt_count",  "R11", 32'(pkt_count),  32'(e_pkts & 255));
      cmp("err_count",  "R8",  32'(err_count),  32'(e_errs & 255));
      cmp("err_code",   "R9",  32'(err_code),   32'(e_code));
   endtask

   task automatic model(input logic [7:0] b, input logic v, input logic l);
      bit was_last = e_pl;
      bit filt;
      int n;
      e_pv = 0; e_pl = 0; e_ps = 0; e_pd = 0;
      if (was_last) e_hv = 0;
      if (!v) return;
      if (mode == 2) begin
         e_pv = 1; e_pd = b; e_pl = l; e_ps = (npay == 0);
         if (npay == 0) begin
            e_hv    = 1;
            e_proto = fq[23];
            e_len   = {fq[16], fq[17]} - 16'd20;
            e_src   = {fq[26], fq[27], fq[28], fq[29]};
            e_pkts++;
         end
         npay++;
         if (l) begin mode = 0; fq.delete(); end
      end else if (mode == 1) begin
         if (l) begin mode = 0; fq.delete(); end
      end else begin
         fq.push_back(b);
         n = fq.size() - 1;
         filt = (n == 12 && b != 8'h08) || (n == 13 && b != 8'h00) ||
                (n >= 30 && b != LOCAL[8*(33-n) +: 8]);
         if (filt) begin
            if (l) fq.delete(); else mode = 1;
         end else if (n == 14 && b != 8'h45) begin
            e_errs++; e_code = 2;
            if (l) fq.delete(); else mode = 1;
         end else if (l) begin
            e_errs++; e_code = 1; fq.delete();
         end else if (n == 33) begin
            mode = 2; npay = 0;
         end
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic push(input logic [7:0] b, input logic v, input logic l);
      in_data = b; in_valid = v; in_last = l;
      @(posedge clk);
      model(b, v, l);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) push(8'h00, 1'b0, 1'b0);
   endtask

   task automatic build(input logic [15:0] etype, input logic [7:0] verb,
                        input logic [15:0] tlen, input logic [7:0] proto,
                        input logic [31:0] src, input logic [31:0] dst,
                        input int np, input logic [7:0] seed);
      fr.delete();
      fr.push_back(8'h00); fr.push_back(8'h23); fr.push_back(8'h20);
      fr.push_back(8'h21); fr.push_back(8'h22); fr.push_back(8'h23);
      fr.push_back(8'h02); fr.push_back(8'h12); fr.push_back(8'h03);
      fr.push_back(8'h23); fr.push_back(8'h04); fr.push_back(8'h54);
      fr.push_back(etype[15:8]); fr.push_back(etype[7:0]);
      fr.push_back(verb); fr.push_back(8'h00);
      fr.push_back(tlen[15:8]); fr.push_back(tlen[7:0]);
      fr.push_back(8'h00); fr.push_back(8'h00);
      fr.push_back(8'h00); fr.push_back(8'h00);
      fr.push_back(8'h40); fr.push_back(proto);
      fr.push_back(8'h00); fr.push_back(8'h00);
      for (int i = 3; i >= 0; i--) fr.push_back(src[8*i +: 8]);
      for (int i = 3; i >= 0; i--) fr.push_back(dst[8*i +: 8]);
      for (int i = 0; i < np; i++) fr.push_back(seed + 8'(i));
   endtask

   // cut > 0 sends only the first cut bytes; gap > 0 inserts an idle cycle before every gap-th byte
   task automatic send(input int cut, input int gap);
      int total = (cut > 0) ? cut : fr.size();
      for (int i = 0; i < total; i++) begin
         if (gap > 0 && (i % gap) == gap - 1) push(8'h00, 1'b0, 1'b0);
         push(fr[i], 1'b1, i == total - 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      cur_req = "R7";                    // outputs during reset
      compare_all();
      rst = 1'b0;
      @(negedge clk);
      compare_all();                     // R7: just after release

      cur_req = "R4";                    // basic accepted frame, R3 R5 R10
      build(16'h0800, 8'h45, 16'h0018, 8'h11, 32'hc0a80501, LOCAL, 4, 8'h24);
      send(0, 0);
      idle(3);

      cur_req = "R1";                    // non-IPv4 type, full length
      build(16'h0806, 8'h45, 16'h0018, 8'h11, 32'hc0a80501, LOCAL, 10, 8'h30);
      send(0, 0);
      idle(2);
      cur_req = "R1";                    // non-IPv4 frame ending inside the header: no error
      build(16'h86dd, 8'h45, 16'h0018, 8'h11, 32'hc0a80501, LOCAL, 0, 8'h00);
      send(14, 0);
      idle(2);

      cur_req = "R2";                    // foreign destination address
      build(16'h0800, 8'h45, 16'h0019, 8'h06, 32'h0a000002, 32'hc0a80508, 5, 8'h40);
      send(0, 0);
      idle(2);

      cur_req = "R6";                    // gaps inside header and payload, R3 new fields
      build(16'h0800, 8'h45, 16'h0021, 8'h06, 32'h0a000001, LOCAL, 13, 8'h90);
      send(0, 3);
      idle(2);

      cur_req = "R8";                    // truncated mid header
      build(16'h0800, 8'h45, 16'h0018, 8'h11, 32'hc0a80501, LOCAL, 4, 8'h00);
      send(21, 0);
      idle(1);
      cur_req = "R8";                    // last on the final header byte
      send(34, 0);
      idle(1);

      cur_req = "R9";                    // bad version byte
      build(16'h0800, 8'h46, 16'h0018, 8'h11, 32'hc0a80501, LOCAL, 3, 8'h00);
      send(0, 0);
      idle(1);

      cur_req = "R5";                    // one byte payload, then a frame with no idle between
      build(16'h0800, 8'h45, 16'h0015, 8'h01, 32'h01020304, LOCAL, 1, 8'haa);
      send(0, 0);
      build(16'h0800, 8'h45, 16'h0016, 8'h02, 32'h05060708, LOCAL, 2, 8'hbb);
      send(0, 0);
      idle(2);

      cur_req = "R11";                   // counter wrap
      for (int k = 0; k < 256; k++) begin
         build(16'h0800, 8'h45, 16'h0015, 8'(k), 32'(k) ^ 32'h11223344, LOCAL, 1, 8'(k));
         send(0, 0);
      end
      idle(3);

      cur_req = "R10";                   // good frame after errors leaves error state alone
      build(16'h0800, 8'h45, 16'h0014, 8'h11, 32'hc0a80501, LOCAL, 2, 8'h55);
      send(0, 0);
      idle(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule